// File: doc/BRIEF.md
# Flash Command Interface Controller

This block sits in front of a small byte-wide flash storage model. It turns a stream of bus writes into commands and decides what later bus reads return. Reads can come from the storage array, from a status byte, or from two fixed identification bytes. Some commands take one write. The two program commands take several writes, and each of those writes carries an address and a data byte.

A program does not change the array straight away. It arms a busy counter that stands in for the real program timing. While the counter runs, the block ignores every command except the one that selects status reads. The staged bytes are merged into the array only when the counter expires. At that point the block rejects the operation if an address lies in a protected block, or if a four-byte group breaks the address rule; either case sets a sticky error bit. An erase pin, intended as a test hook, fills one whole block with ones.

The bus is a plain synchronous strobe interface and has no back-pressure. Every write strobe is taken in the cycle it is seen. A read strobe is answered one cycle later with a valid pulse. The block never stalls the bus: a command that cannot be accepted is dropped, not held.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset the block is in array-read mode, every array byte reads 0xFF, the status byte is 0x80 and `bus_rvalid` is low.
- R2: Each of the codes 0xFF (array reads), 0x70 (status reads) and 0x90 (identifier reads) takes one write, and the selected read source holds until another accepted command changes it.
- R3: In identifier mode, a read at address 0 returns 0x20, a read at address 1 returns 0x2F, and a read at any other address returns 0x00.
- R4: Code 0x40 followed by a second write programs one byte. The second write captures the address and data and makes the block busy for BUSY_CYC cycles. Reads then return status, with bit 7 = 0 while busy and bit 7 = 1 once idle.
- R5: A program stores old AND new data in the cell, so a bit that is 0 never returns to 1.
- R6: A program that touches a block whose `blk_protect` bit is set leaves the array unchanged and sets status bit 1.
- R7: While busy, a write of 0x70 selects status reads. Every other write is ignored, including 0xFF and new program codes.
- R8: Code 0x30 followed by four address/data writes programs four bytes. The fourth of those writes starts the busy period, and all four bytes are merged when it ends.
- R9: The four addresses of a 0x30 program may differ from the first one only in bits 0 and 10. Otherwise the array is unchanged and status bit 4 is set.
- R10: Status bits 4 and 1 stay set until a 0x50 write clears both. A 0x50 write leaves the read source unchanged.
- R11: Any other code written when no sequence is pending is ignored and leaves the read source unchanged.
- R12: A pulse on `tst_erase` sets every byte of block `tst_erase_blk` (address bits ADDR_W-1 down to BLK_AW) to 0xFF.
- R13: A read strobe without a write strobe gives `bus_rvalid` high with data in the next cycle. A read strobe together with a write strobe is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe; address and data are taken this cycle |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address for reads and writes |
| bus_wdata | input | 8 | Command code or program data |
| bus_rdata | output | 8 | Read data, valid with `bus_rvalid` |
| bus_rvalid | output | 1 | One-cycle pulse after an accepted read strobe |
| blk_protect | input | 2**(ADDR_W-BLK_AW) | One protect flag per block, sampled when a program completes |
| tst_erase | input | 1 | Test hook: fill one block with 0xFF |
| tst_erase_blk | input | ADDR_W-BLK_AW | Block selected by the erase hook |

## Verification
The bench sends program and mode codes while a program is running. A design without the lockout would leave status mode or start a second program, and a read issued right after would no longer show a busy status byte. The same cell is programmed twice with values that conflict. A design that overwrites instead of ANDing would return the second value rather than 0x00. Four-byte groups are used in three forms: one that legally flips bit 10 across two blocks, one that breaks the address rule, and one that lands in a protected block. A wrong rule check would write to the array or set the wrong error bit. The bench also tests that errors stay set across mode changes, and that a read strobe arriving together with a write strobe is dropped.

// File: rtl/flc_pkg.sv
package flc_pkg;
  localparam logic [7:0] CMD_RD_ARRAY = 8'hFF;
  localparam logic [7:0] CMD_RD_STAT  = 8'h70;
  localparam logic [7:0] CMD_RD_ID    = 8'h90;
  localparam logic [7:0] CMD_PROG     = 8'h40;
  localparam logic [7:0] CMD_PROG4    = 8'h30;
  localparam logic [7:0] CMD_CLR      = 8'h50;

  localparam logic [7:0] ID_MAKER = 8'h20;
  localparam logic [7:0] ID_PART  = 8'h2F;

  localparam int LANES = 4;

  typedef enum logic [1:0] {MODE_ARRAY, MODE_STATUS, MODE_IDENT} rmode_t;
  typedef enum logic [1:0] {SQ_IDLE, SQ_PROG, SQ_PROG4} seq_t;
endpackage

// File: rtl/flc_sequencer.sv
module flc_sequencer
  import flc_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              busy,
  output rmode_t            mode,
  output logic              start,
  output logic              clr_err,
  output logic              quad,
  output logic [ADDR_W-1:0] lane_addr [LANES],
  output logic [7:0]        lane_data [LANES]
);
  localparam int IDX_W = $clog2(LANES);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LANES - 1);

  seq_t              seq_q;
  logic [IDX_W-1:0]  idx_q;
  rmode_t            mode_q;
  logic              quad_q;
  logic [ADDR_W-1:0] la_q [LANES];
  logic [7:0]        ld_q [LANES];
  logic              idle_wr;

  assign idle_wr = wr && !busy;
  assign start   = idle_wr && ((seq_q == SQ_PROG) ||
                               (seq_q == SQ_PROG4 && idx_q == LAST_IDX));
  assign clr_err = idle_wr && (seq_q == SQ_IDLE) && (wdata == CMD_CLR);
  assign mode    = mode_q;
  assign quad    = quad_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane_out
    assign lane_addr[g] = la_q[g];
    assign lane_data[g] = ld_q[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_q  <= SQ_IDLE;
      idx_q  <= '0;
      mode_q <= MODE_ARRAY;
      quad_q <= 1'b0;
      for (int l = 0; l < LANES; l++) begin
        la_q[l] <= '0;
        ld_q[l] <= '0;
      end
    end else if (wr) begin
      if (busy) begin
        if (wdata == CMD_RD_STAT) mode_q <= MODE_STATUS;
      end else begin
        case (seq_q)
          SQ_IDLE: begin
            case (wdata)
              CMD_RD_ARRAY: mode_q <= MODE_ARRAY;
              CMD_RD_STAT:  mode_q <= MODE_STATUS;
              CMD_RD_ID:    mode_q <= MODE_IDENT;
              CMD_PROG: begin
                seq_q  <= SQ_PROG;
                mode_q <= MODE_STATUS;
              end
              CMD_PROG4: begin
                seq_q  <= SQ_PROG4;
                idx_q  <= '0;
                mode_q <= MODE_STATUS;
              end
              default: ;
            endcase
          end
          SQ_PROG: begin
            la_q[0] <= addr;
            ld_q[0] <= wdata;
            quad_q  <= 1'b0;
            seq_q   <= SQ_IDLE;
          end
          SQ_PROG4: begin
            la_q[idx_q] <= addr;
            ld_q[idx_q] <= wdata;
            idx_q       <= idx_q + 1'b1;
            if (idx_q == LAST_IDX) begin
              seq_q  <= SQ_IDLE;
              quad_q <= 1'b1;
            end
          end
          default: seq_q <= SQ_IDLE;
        endcase
      end
    end
  end

  // R7: while busy, only the status-read code has any effect
  p_busy_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr && wdata != CMD_RD_STAT) |=> ($stable(mode_q) && $stable(seq_q)));
  p_busy_stat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr && wdata == CMD_RD_STAT) |=> (mode_q == MODE_STATUS));
  // R11: unknown first-cycle codes leave the state alone
  p_unknown_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_wr && seq_q == SQ_IDLE && wdata != CMD_RD_ARRAY && wdata != CMD_RD_STAT &&
     wdata != CMD_RD_ID && wdata != CMD_PROG && wdata != CMD_PROG4)
    |=> ($stable(mode_q) && seq_q == SQ_IDLE));
endmodule

// File: rtl/flc_busy_timer.sv
module flc_busy_timer #(
  parameter int BUSY_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CNT_W = $clog2(BUSY_CYC + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(BUSY_CYC);

  logic [CNT_W-1:0] cnt_q;

  assign busy = (cnt_q != '0);
  assign done = (cnt_q == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (start) cnt_q <= LOAD;
    else if (busy)  cnt_q <= cnt_q - 1'b1;
  end

  // R4: a start only comes from an idle block and always raises busy
  p_start_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);
  p_start_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);
  p_done_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
endmodule

// File: rtl/flc_status.sv
module flc_status
  import flc_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int BLK_AW = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          done,
  input  logic                          clr_err,
  input  logic                          quad,
  input  logic [LANES-1:0]              lane_vld,
  input  logic [ADDR_W-1:0]             lane_addr [LANES],
  input  logic [(1<<(ADDR_W-BLK_AW))-1:0] blk_protect,
  output logic                          commit,
  output logic                          perr,
  output logic                          lerr
);
  localparam logic [ADDR_W-1:0] FREE_BITS = ADDR_W'(1) | (ADDR_W'(1) << 10);

  logic rule_ok, prot_hit;
  logic perr_q, lerr_q;

  always_comb begin
    rule_ok = 1'b1;
    if (quad) begin
      for (int l = 1; l < LANES; l++) begin
        if (((lane_addr[l] ^ lane_addr[0]) & ~FREE_BITS) != '0) rule_ok = 1'b0;
      end
    end
  end

  always_comb begin
    prot_hit = 1'b0;
    for (int l = 0; l < LANES; l++) begin
      if (lane_vld[l] && blk_protect[lane_addr[l][ADDR_W-1:BLK_AW]]) prot_hit = 1'b1;
    end
  end

  assign commit = done && rule_ok && !prot_hit;
  assign perr   = perr_q;
  assign lerr   = lerr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      perr_q <= 1'b0;
      lerr_q <= 1'b0;
    end else if (clr_err) begin
      perr_q <= 1'b0;
      lerr_q <= 1'b0;
    end else if (done) begin
      if (!rule_ok)      perr_q <= 1'b1;
      else if (prot_hit) lerr_q <= 1'b1;
    end
  end

  // R10: error flags only drop on a clear
  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (perr_q && !clr_err) |=> perr_q);
  p_lerr_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (lerr_q && !clr_err) |=> lerr_q);
  // R6: a protected hit raises the protect error
  p_prot_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && rule_ok && prot_hit) |=> lerr_q);
  // R9: a broken address group raises the program error
  p_rule_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !rule_ok) |=> perr_q);
endmodule

// File: rtl/flc_array.sv
module flc_array
  import flc_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int BLK_AW = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       erase,
  input  logic [ADDR_W-BLK_AW-1:0]   erase_blk,
  input  logic                       commit,
  input  logic [LANES-1:0]           lane_vld,
  input  logic [ADDR_W-1:0]          lane_addr [LANES],
  input  logic [7:0]                 lane_data [LANES],
  input  logic [ADDR_W-1:0]          rd_addr,
  output logic [7:0]                 rd_byte
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int BIDX_W = ADDR_W - BLK_AW;

  logic [7:0] mem_q [DEPTH];
  logic [7:0] mem_d [DEPTH];

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      mem_d[i] = mem_q[i];
      if (erase && BIDX_W'(i >> BLK_AW) == erase_blk) mem_d[i] = 8'hFF;
      for (int l = 0; l < LANES; l++) begin
        if (commit && lane_vld[l] && lane_addr[l] == ADDR_W'(i))
          mem_d[i] = mem_d[i] & lane_data[l];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
    end else begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_d[i];
    end
  end

  assign rd_byte = mem_q[rd_addr];

  // R5: programming never sets a bit
  p_only_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !erase) |=>
      ((mem_q[$past(lane_addr[0])] & ~$past(mem_q[lane_addr[0]])) == 8'h00));
  // R12: the erase hook fills its block
  p_erase_fill_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (erase && !commit) |=> (mem_q[{$past(erase_blk), BLK_AW'(0)}] == 8'hFF));
endmodule

// File: rtl/flc_readpath.sv
module flc_readpath
  import flc_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  rmode_t            mode,
  input  logic              busy,
  input  logic              perr,
  input  logic              lerr,
  input  logic [7:0]        arr_byte,
  output logic [7:0]        rdata,
  output logic              rvalid
);
  logic [7:0] stat_byte, id_byte;
  logic       take;
  logic [7:0] rdata_q;
  logic       rvalid_q;

  assign take      = rd && !wr;
  assign stat_byte = {!busy, 2'b00, perr, 2'b00, lerr, 1'b0};

  always_comb begin
    if (addr == ADDR_W'(0))      id_byte = ID_MAKER;
    else if (addr == ADDR_W'(1)) id_byte = ID_PART;
    else                         id_byte = 8'h00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q  <= 8'h00;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= take;
      if (take) begin
        case (mode)
          MODE_ARRAY:  rdata_q <= arr_byte;
          MODE_STATUS: rdata_q <= stat_byte;
          MODE_IDENT:  rdata_q <= id_byte;
          default:     rdata_q <= 8'h00;
        endcase
      end
    end
  end

  assign rdata  = rdata_q;
  assign rvalid = rvalid_q;

  // R13: one valid pulse per lone read strobe
  p_rvalid_r13: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> rvalid_q);
  p_drop_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && wr) |=> !rvalid_q);
  // R3: identifier byte at address zero
  p_ident_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (take && mode == MODE_IDENT && addr == ADDR_W'(0)) |=> (rdata_q == 8'h20));
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flc_pkg::*;
#(
  parameter int ADDR_W   = 11,
  parameter int BLK_AW   = 8,
  parameter int BUSY_CYC = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              bus_wr,
  input  logic                              bus_rd,
  input  logic [ADDR_W-1:0]                 bus_addr,
  input  logic [7:0]                        bus_wdata,
  output logic [7:0]                        bus_rdata,
  output logic                              bus_rvalid,
  input  logic [(1<<(ADDR_W-BLK_AW))-1:0]   blk_protect,
  input  logic                              tst_erase,
  input  logic [ADDR_W-BLK_AW-1:0]          tst_erase_blk
);
  rmode_t            mode;
  logic              start, clr_err, quad, busy, done, commit, perr, lerr;
  logic [ADDR_W-1:0] lane_addr [LANES];
  logic [7:0]        lane_data [LANES];
  logic [LANES-1:0]  lane_vld;
  logic [7:0]        arr_byte;

  assign lane_vld[0] = 1'b1;
  for (genvar g = 1; g < LANES; g++) begin : g_vld
    assign lane_vld[g] = quad;
  end

  flc_sequencer #(.ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .busy(busy), .mode(mode), .start(start), .clr_err(clr_err), .quad(quad),
    .lane_addr(lane_addr), .lane_data(lane_data)
  );

  flc_busy_timer #(.BUSY_CYC(BUSY_CYC)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done)
  );

  flc_status #(.ADDR_W(ADDR_W), .BLK_AW(BLK_AW)) u_stat (
    .clk(clk), .rst_n(rst_n), .done(done), .clr_err(clr_err), .quad(quad),
    .lane_vld(lane_vld), .lane_addr(lane_addr), .blk_protect(blk_protect),
    .commit(commit), .perr(perr), .lerr(lerr)
  );

  flc_array #(.ADDR_W(ADDR_W), .BLK_AW(BLK_AW)) u_arr (
    .clk(clk), .rst_n(rst_n), .erase(tst_erase), .erase_blk(tst_erase_blk),
    .commit(commit), .lane_vld(lane_vld), .lane_addr(lane_addr),
    .lane_data(lane_data), .rd_addr(bus_addr), .rd_byte(arr_byte)
  );

  flc_readpath #(.ADDR_W(ADDR_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd(bus_rd), .wr(bus_wr), .addr(bus_addr),
    .mode(mode), .busy(busy), .perr(perr), .lerr(lerr), .arr_byte(arr_byte),
    .rdata(bus_rdata), .rvalid(bus_rvalid)
  );
endmodule

// File: tb/flash_cmd_ctrl_test.sv
`timescale 1ns/1ps
module flash_cmd_ctrl_test;
  localparam int ADDR_W = 11, BLK_AW = 8, BUSY = 8;
  localparam int DEPTH = 1 << ADDR_W, NBLK = 1 << (ADDR_W - BLK_AW), BIDX_W = ADDR_W - BLK_AW;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, bus_wr, bus_rd, tst_erase;
  logic [ADDR_W-1:0] bus_addr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic bus_rvalid;
  logic [NBLK-1:0] blk_protect;
  logic [BIDX_W-1:0] tst_erase_blk;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  flash_cmd_ctrl #(.ADDR_W(ADDR_W), .BLK_AW(BLK_AW), .BUSY_CYC(BUSY)) uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .blk_protect(blk_protect), .tst_erase(tst_erase), .tst_erase_blk(tst_erase_blk)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [7:0] m_mem [DEPTH];
  int m_mode, m_seq, m_idx, m_cnt;
  bit m_quad, m_perr, m_lerr, m_busy, m_fin, e_rvalid;
  int m_la [4];
  logic [7:0] m_ld [4];
  logic [7:0] e_rdata;

  function automatic logic [7:0] m_read(input int a, input bit bsy);
    if (m_mode == 0) return m_mem[a];
    if (m_mode == 1) return {~bsy, 2'b00, m_perr, 2'b00, m_lerr, 1'b0};
    if (a == 0) return 8'h20;
    if (a == 1) return 8'h2F;
    return 8'h00;
  endfunction

  task automatic m_complete();
    bit rule, prot;
    int n;
    n = m_quad ? 4 : 1;
    rule = 1'b1;
    prot = 1'b0;
    for (int k = 0; k < n; k++) begin
      if (((m_la[k] ^ m_la[0]) & ~32'h401) != 0) rule = 1'b0;
      if (blk_protect[m_la[k] >> BLK_AW]) prot = 1'b1;
    end
    if (!rule) m_perr = 1'b1;
    else if (prot) m_lerr = 1'b1;
    else for (int k = 0; k < n; k++) m_mem[m_la[k]] = m_mem[m_la[k]] & m_ld[k];
  endtask

  task automatic m_write(input int a, input logic [7:0] d, input bit bsy);
    if (bsy) begin
      if (d == 8'h70) m_mode = 1;
    end else if (m_seq == 0) begin
      case (d)
        8'hFF: m_mode = 0;
        8'h70: m_mode = 1;
        8'h90: m_mode = 2;
        8'h40: begin m_seq = 1; m_mode = 1; end
        8'h30: begin m_seq = 2; m_idx = 0; m_mode = 1; end
        8'h50: begin m_perr = 0; m_lerr = 0; end
        default: ;
      endcase
    end else if (m_seq == 1) begin
      m_la[0] = a; m_ld[0] = d; m_quad = 0; m_seq = 0; m_cnt = BUSY;
    end else begin
      m_la[m_idx] = a; m_ld[m_idx] = d; m_idx++;
      if (m_idx == 4) begin m_seq = 0; m_quad = 1; m_cnt = BUSY; end
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) m_mem[i] = 8'hFF;
      m_mode = 0; m_seq = 0; m_idx = 0; m_cnt = 0;
      m_quad = 0; m_perr = 0; m_lerr = 0; e_rvalid = 0; e_rdata = 8'h00;
    end else begin
      m_busy = (m_cnt != 0);
      e_rvalid = bus_rd && !bus_wr;
      if (e_rvalid) e_rdata = m_read(int'(bus_addr), m_busy);
      m_fin = (m_cnt == 1);
      if (m_cnt != 0) m_cnt--;
      if (tst_erase)
        for (int i = 0; i < (1 << BLK_AW); i++) m_mem[(int'(tst_erase_blk) << BLK_AW) + i] = 8'hFF;
      if (m_fin) m_complete();
      if (bus_wr) m_write(int'(bus_addr), bus_wdata, m_busy);
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check("R13 model rvalid", {7'd0, bus_rvalid}, {7'd0, e_rvalid});
      if (e_rvalid) check("R13 model rdata", bus_rdata, e_rdata);
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = ADDR_W'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input int a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = ADDR_W'(a);
    @(negedge clk);
    bus_rd = 1'b0;
    check(tag, {7'd0, bus_rvalid}, 8'd1);
    check(tag, bus_rdata, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog R13: got hung run expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_wr = 0; bus_rd = 0; bus_addr = '0; bus_wdata = '0;
    blk_protect = '0; tst_erase = 0; tst_erase_blk = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 rvalid after reset", {7'd0, bus_rvalid}, 8'd0);
    rd_chk(5, 8'hFF, "R1 array after reset");
    rd_chk(12'h7FF, 8'hFF, "R1 top cell after reset");

    wr(0, 8'h70);
    rd_chk(0, 8'h80, "R2 status select idle");
    wr(0, 8'h90);
    rd_chk(0, 8'h20, "R3 id byte 0");
    rd_chk(1, 8'h2F, "R3 id byte 1");
    rd_chk(2, 8'h00, "R3 id other address");
    rd_chk(0, 8'h20, "R2 id mode held");
    wr(0, 8'h12);
    rd_chk(1, 8'h2F, "R11 unknown code ignored");

    // single program and busy lockout
    wr(0, 8'h40);
    wr(12'h123, 8'h5A);
    rd_chk(0, 8'h00, "R4 busy status");
    wr(0, 8'hFF);
    rd_chk(0, 8'h00, "R7 read-array ignored while busy");
    wr(0, 8'h40);
    idle(12);
    rd_chk(0, 8'h80, "R4 ready after busy");
    wr(12'h050, 8'h00);
    rd_chk(0, 8'h80, "R7 program code ignored while busy");
    wr(0, 8'hFF);
    rd_chk(12'h123, 8'h5A, "R4 programmed byte");
    rd_chk(12'h050, 8'hFF, "R7 no stray program");

    wr(0, 8'h40); wr(12'h123, 8'hA5); idle(12);
    wr(0, 8'hFF);
    rd_chk(12'h123, 8'h00, "R5 and of conflicting data");
    wr(0, 8'h40); wr(12'h124, 8'hF0); idle(12);
    wr(0, 8'h40); wr(12'h124, 8'h3C); idle(12);
    wr(0, 8'hFF);
    rd_chk(12'h124, 8'h30, "R5 bits only clear");

    // protected block
    blk_protect[2] = 1'b1;
    wr(0, 8'h40); wr(12'h205, 8'h00); idle(12);
    rd_chk(0, 8'h82, "R6 protect error bit");
    wr(0, 8'hFF);
    rd_chk(12'h205, 8'hFF, "R6 protected cell unchanged");
    wr(0, 8'h70);
    rd_chk(0, 8'h82, "R10 error held across commands");
    wr(0, 8'h50);
    rd_chk(0, 8'h80, "R10 clear keeps status mode");

    // legal four-byte program across bit 10
    wr(0, 8'h30);
    wr(12'h310, 8'h11); wr(12'h311, 8'h22); wr(12'h710, 8'h33); wr(12'h711, 8'h44);
    rd_chk(0, 8'h00, "R8 busy after fifth write");
    idle(10);
    rd_chk(0, 8'h80, "R8 ready");
    wr(0, 8'hFF);
    rd_chk(12'h310, 8'h11, "R8 byte 0");
    rd_chk(12'h311, 8'h22, "R8 byte 1");
    rd_chk(12'h710, 8'h33, "R8 byte 2");
    rd_chk(12'h711, 8'h44, "R8 byte 3");

    // broken address group
    wr(0, 8'h30);
    wr(12'h020, 8'h00); wr(12'h021, 8'h00); wr(12'h022, 8'h00); wr(12'h420, 8'h00);
    idle(12);
    rd_chk(0, 8'h90, "R9 rule error bit");
    wr(0, 8'hFF);
    rd_chk(12'h022, 8'hFF, "R9 array unchanged");
    rd_chk(12'h020, 8'hFF, "R9 first byte unchanged");
    wr(0, 8'h50);
    rd_chk(12'h020, 8'hFF, "R10 clear keeps array mode");

    // four-byte program into a protected block
    wr(0, 8'h30);
    wr(12'h200, 8'h01); wr(12'h201, 8'h02); wr(12'h600, 8'h03); wr(12'h601, 8'h04);
    idle(12);
    rd_chk(0, 8'h82, "R6 four-byte protect error");
    wr(0, 8'h50);
    wr(0, 8'hFF);
    rd_chk(12'h600, 8'hFF, "R6 four-byte unchanged");

    // erase hook
    @(negedge clk); tst_erase = 1'b1; tst_erase_blk = 3'd3;
    @(negedge clk); tst_erase = 1'b0;
    rd_chk(12'h310, 8'hFF, "R12 erased block");
    rd_chk(12'h3FF, 8'hFF, "R12 erased block end");
    rd_chk(12'h710, 8'h33, "R12 other block kept");

    // read with write in the same cycle
    @(negedge clk); bus_wr = 1'b1; bus_rd = 1'b1; bus_wdata = 8'h90; bus_addr = '0;
    @(negedge clk); bus_wr = 1'b0; bus_rd = 1'b0;
    check("R13 read with write dropped", {7'd0, bus_rvalid}, 8'd0);
    rd_chk(0, 8'h20, "R2 id selected by that write");

    idle(4);
    finished = 1'b1;
    summary();
    $finish;
  end
endmodule